// File: doc/BRIEF.md
# Single-Cycle Stack Processor Control Decoder

This block is the purely combinational steering logic that sits between the fetch stage and the datapath of a single-cycle 32-bit processor whose call, return, push and pop instructions move a stack pointer kept in the general register file. The fetch logic supplies the decoded opcode, function code, the two register ids and the constant word. The block reports which registers to read and which to write. It drives the two ALU operands and the ALU function. It produces the memory strobes, the memory address and the store data. It also selects the next program counter.

The register file, the ALU and the memory sit outside the block. The block reads back from them the two register values, the ALU result and the memory read data. These feed the same combinational cone, so each instruction completes within one clock cycle of the enclosing processor. In one cycle, a pop writes both the loaded value and the adjusted stack pointer. A return takes its target from the memory read data. Stack pointer adjustment is done by feeding a constant plus or minus step into the ALU.

Top module: `cpu_step_ctrl`

## Requirements
- R1: Opcodes are 4 bits: 0 nop, 1 halt, 2 reg-to-reg move, 3 immediate-to-reg move, 4 store (reg to mem), 5 load (mem to reg), 6 ALU op, 7 conditional jump, 8 call, 9 return, 10 push, 11 pop. Register id 4 is the stack pointer and id 8 means no register. `src_a` is `ra_id` for opcodes 2, 4, 6 and 10. It is 4 for opcodes 9 and 11, and 8 otherwise.
- R2: `src_b` is `rb_id` for opcodes 4, 5 and 6. It is 4 for opcodes 8, 9, 10 and 11, and 8 otherwise.
- R3: `dst_alu` is `rb_id` for opcodes 2, 3 and 6. It is 4 for opcodes 8, 9, 10 and 11, and 8 otherwise.
- R4: `dst_mem` is `ra_id` for opcodes 5 and 11, and 8 otherwise. A pop therefore names two write targets at once, and with `ra_id` = 4 both are 4.
- R5: `alu_in_a` is `rd_a` for opcodes 2 and 6, and `const_w` for opcodes 3, 4 and 5. It is -4 for opcodes 8 and 10, +4 for opcodes 9 and 11, and 0 otherwise.
- R6: `alu_in_b` is 0 for opcodes 2 and 3, and `rd_b` for every other opcode.
- R7: `alu_fn` equals `fn_code` for opcode 6 and is 0 (add) for every other opcode. Function codes are 0 add, 1 subtract, 2 and, 3 xor.
- R8: `mem_rd` is high exactly for opcodes 5, 9 and 11. `mem_wr` is high exactly for opcodes 4, 8 and 10. The two are never high together.
- R9: `mem_addr` is `rd_a` for opcodes 9 and 11, and `alu_res` otherwise.
- R10: `mem_wdata` is `seq_pc` for opcode 8 and `rd_a` otherwise.
- R11: `next_pc` is `const_w` for opcode 8 and for opcode 7 with `br_take` high. It is `mem_rdata` for opcode 9, and `seq_pc` otherwise, including opcode 7 with `br_take` low.
- R12: Opcodes 12 to 15 name no source or destination register. They raise no memory strobe, select add, and give `next_pc` = `seq_pc` whatever `br_take` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Instruction opcode |
| fn_code | input | 4 | Instruction function code |
| ra_id | input | 4 | First register id field |
| rb_id | input | 4 | Second register id field |
| const_w | input | 32 | Constant word (immediate, displacement or target) |
| seq_pc | input | 32 | Address of the following instruction |
| rd_a | input | 32 | Register file read data, port A |
| rd_b | input | 32 | Register file read data, port B |
| alu_res | input | 32 | ALU result |
| mem_rdata | input | 32 | Memory read data |
| br_take | input | 1 | Branch condition met |
| src_a | output | 4 | Register read select A |
| src_b | output | 4 | Register read select B |
| dst_alu | output | 4 | Write target for the ALU result |
| dst_mem | output | 4 | Write target for the memory result |
| alu_in_a | output | 32 | ALU operand A |
| alu_in_b | output | 32 | ALU operand B |
| alu_fn | output | 4 | ALU function |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| next_pc | output | 32 | Program counter for the next cycle |

## Verification
The block holds no state, so a wrong decode shows at the ports in the same evaluation as the opcode that triggers it, and only for that opcode. A mis-steered selector for one opcode shows as a wrong register id, a wrong operand value or a wrong strobe, and it is visible at once. To make every mux leg tell itself apart, the data inputs carry distinct values. The stack cases get extra attention: a pop whose destination is the stack pointer, a return whose address must come from the old stack pointer, and jumps with the condition both met and not met.

// File: rtl/cpu_step_ctrl.sv
module cpu_step_ctrl #(
  parameter int DW     = 32,
  parameter int RW     = 4,
  parameter int CW     = 4,
  parameter int SP_ID  = 4,
  parameter int NO_REG = 8,
  parameter int STEP   = 4
) (
  input  logic [CW-1:0] op_code,
  input  logic [CW-1:0] fn_code,
  input  logic [RW-1:0] ra_id,
  input  logic [RW-1:0] rb_id,
  input  logic [DW-1:0] const_w,
  input  logic [DW-1:0] seq_pc,
  input  logic [DW-1:0] rd_a,
  input  logic [DW-1:0] rd_b,
  input  logic [DW-1:0] alu_res,
  input  logic [DW-1:0] mem_rdata,
  input  logic          br_take,
  output logic [RW-1:0] src_a,
  output logic [RW-1:0] src_b,
  output logic [RW-1:0] dst_alu,
  output logic [RW-1:0] dst_mem,
  output logic [DW-1:0] alu_in_a,
  output logic [DW-1:0] alu_in_b,
  output logic [CW-1:0] alu_fn,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] next_pc
);
  localparam logic [CW-1:0] OP_RRMOV = CW'(2);
  localparam logic [CW-1:0] OP_IRMOV = CW'(3);
  localparam logic [CW-1:0] OP_STORE = CW'(4);
  localparam logic [CW-1:0] OP_LOAD  = CW'(5);
  localparam logic [CW-1:0] OP_ALU   = CW'(6);
  localparam logic [CW-1:0] OP_JUMP  = CW'(7);
  localparam logic [CW-1:0] OP_CALL  = CW'(8);
  localparam logic [CW-1:0] OP_RET   = CW'(9);
  localparam logic [CW-1:0] OP_PUSH  = CW'(10);
  localparam logic [CW-1:0] OP_POP   = CW'(11);
  localparam logic [CW-1:0] FN_ADD   = '0;
  localparam logic [RW-1:0] SP       = RW'(SP_ID);
  localparam logic [RW-1:0] NR       = RW'(NO_REG);
  localparam logic [DW-1:0] STEP_UP  = DW'(STEP);
  localparam logic [DW-1:0] STEP_DN  = DW'(-STEP);

  logic is_rr, is_ir, is_st, is_ld, is_op, is_jmp, is_call, is_ret, is_push, is_pop;
  logic uses_sp, pops_sp;

  assign is_rr   = op_code == OP_RRMOV;
  assign is_ir   = op_code == OP_IRMOV;
  assign is_st   = op_code == OP_STORE;
  assign is_ld   = op_code == OP_LOAD;
  assign is_op   = op_code == OP_ALU;
  assign is_jmp  = op_code == OP_JUMP;
  assign is_call = op_code == OP_CALL;
  assign is_ret  = op_code == OP_RET;
  assign is_push = op_code == OP_PUSH;
  assign is_pop  = op_code == OP_POP;

  assign pops_sp = is_ret | is_pop;
  assign uses_sp = pops_sp | is_call | is_push;

  assign src_a   = (is_rr | is_st | is_op | is_push) ? ra_id :
                   pops_sp                           ? SP    : NR;
  assign src_b   = (is_op | is_st | is_ld) ? rb_id :
                   uses_sp                 ? SP    : NR;
  assign dst_alu = (is_rr | is_ir | is_op) ? rb_id :
                   uses_sp                 ? SP    : NR;
  assign dst_mem = (is_ld | is_pop) ? ra_id : NR;

  always_comb begin
    if (is_rr | is_op)               alu_in_a = rd_a;
    else if (is_ir | is_st | is_ld)  alu_in_a = const_w;
    else if (is_call | is_push)      alu_in_a = STEP_DN;
    else if (pops_sp)                alu_in_a = STEP_UP;
    else                             alu_in_a = '0;
  end

  assign alu_in_b  = (is_rr | is_ir) ? '0 : rd_b;
  assign alu_fn    = is_op ? fn_code : FN_ADD;

  assign mem_rd    = is_ld | pops_sp;
  assign mem_wr    = is_st | is_push | is_call;
  assign mem_addr  = pops_sp ? rd_a : alu_res;
  assign mem_wdata = is_call ? seq_pc : rd_a;

  assign next_pc   = (is_call | (is_jmp & br_take)) ? const_w   :
                     is_ret                         ? mem_rdata : seq_pc;
endmodule

// File: rtl/cpu_step_ctrl_chk.sv
module cpu_step_ctrl_chk #(
  parameter int DW     = 32,
  parameter int RW     = 4,
  parameter int CW     = 4,
  parameter int SP_ID  = 4,
  parameter int NO_REG = 8
) (
  input logic [CW-1:0] op_code,
  input logic [RW-1:0] ra_id,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] next_pc,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [CW-1:0] alu_fn,
  input logic [RW-1:0] dst_alu,
  input logic [RW-1:0] dst_mem
);
  always_comb begin
    p_strobe_excl_r8: assert (!(mem_rd && mem_wr))
      else $error("memory read and write strobes both high");
    if (op_code == CW'(9))
      p_ret_target_r11: assert (next_pc == mem_rdata)
        else $error("return target is not the memory data");
    if (op_code == CW'(11))
      p_pop_dual_dst_r4: assert (dst_alu == RW'(SP_ID) && dst_mem == ra_id)
        else $error("pop does not name both write targets");
    if (op_code != CW'(6))
      p_fn_add_r7: assert (alu_fn == '0)
        else $error("non-ALU opcode did not select add");
    if (op_code > CW'(11))
      p_unused_quiet_r12: assert (!mem_rd && !mem_wr && dst_alu == RW'(NO_REG) && dst_mem == RW'(NO_REG))
        else $error("unused opcode caused activity");
  end
endmodule

bind cpu_step_ctrl cpu_step_ctrl_chk #(
  .DW(DW), .RW(RW), .CW(CW), .SP_ID(SP_ID), .NO_REG(NO_REG)
) u_chk (
  .op_code(op_code), .ra_id(ra_id), .mem_rdata(mem_rdata), .next_pc(next_pc),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .alu_fn(alu_fn),
  .dst_alu(dst_alu), .dst_mem(dst_mem)
);

// File: tb/cpu_step_ctrl_test.sv
module cpu_step_ctrl_test;
  localparam logic [31:0] C = 32'h1000_00C0, P = 32'h0000_0A50, A = 32'h0000_7A7A;
  localparam logic [31:0] B = 32'h0000_B0B0, E = 32'h0000_EEE0, M = 32'h0000_4D40;

  typedef struct packed {
    logic [3:0] op, fn, ra, rb;
    logic       br;
    logic [3:0] sa, sb, de, dm;
    logic [2:0] asel;   // 0 zero, 1 rd_a, 2 const, 3 minus step, 4 plus step
    logic       bzero;
    logic [3:0] fe;
    logic       rd, wr, addr_a, wd_p;
    logic [1:0] pcs;    // 0 seq_pc, 1 const, 2 mem data
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{4'h0,4'h0,4'h1,4'h2,1'b0, 4'h8,4'h8,4'h8,4'h8, 3'd0,1'b0,4'h0, 1'b0,1'b0,1'b0,1'b0,2'd0},
    '{4'h1,4'h0,4'h1,4'h2,1'b0, 4'h8,4'h8,4'h8,4'h8, 3'd0,1'b0,4'h0, 1'b0,1'b0,1'b0,1'b0,2'd0},
    '{4'h2,4'h0,4'h1,4'h2,1'b0, 4'h1,4'h8,4'h2,4'h8, 3'd1,1'b1,4'h0, 1'b0,1'b0,1'b0,1'b0,2'd0},
    '{4'h3,4'h0,4'h8,4'h2,1'b0, 4'h8,4'h8,4'h2,4'h8, 3'd2,1'b1,4'h0, 1'b0,1'b0,1'b0,1'b0,2'd0},
    '{4'h4,4'h0,4'h1,4'h2,1'b0, 4'h1,4'h2,4'h8,4'h8, 3'd2,1'b0,4'h0, 1'b0,1'b1,1'b0,1'b0,2'd0},
    '{4'h5,4'h0,4'h1,4'h2,1'b0, 4'h8,4'h2,4'h8,4'h1, 3'd2,1'b0,4'h0, 1'b1,1'b0,1'b0,1'b0,2'd0},
    '{4'h6,4'h1,4'h1,4'h2,1'b0, 4'h1,4'h2,4'h2,4'h8, 3'd1,1'b0,4'h1, 1'b0,1'b0,1'b0,1'b0,2'd0},
    '{4'h6,4'h3,4'h5,4'h6,1'b1, 4'h5,4'h6,4'h6,4'h8, 3'd1,1'b0,4'h3, 1'b0,1'b0,1'b0,1'b0,2'd0},
    '{4'h7,4'h2,4'h1,4'h2,1'b1, 4'h8,4'h8,4'h8,4'h8, 3'd0,1'b0,4'h0, 1'b0,1'b0,1'b0,1'b0,2'd1},
    '{4'h7,4'h2,4'h1,4'h2,1'b0, 4'h8,4'h8,4'h8,4'h8, 3'd0,1'b0,4'h0, 1'b0,1'b0,1'b0,1'b0,2'd0},
    '{4'h8,4'h0,4'h1,4'h2,1'b0, 4'h8,4'h4,4'h4,4'h8, 3'd3,1'b0,4'h0, 1'b0,1'b1,1'b0,1'b1,2'd1},
    '{4'h9,4'h0,4'h1,4'h2,1'b1, 4'h4,4'h4,4'h4,4'h8, 3'd4,1'b0,4'h0, 1'b1,1'b0,1'b1,1'b0,2'd2},
    '{4'hA,4'h0,4'h1,4'h2,1'b0, 4'h1,4'h4,4'h4,4'h8, 3'd3,1'b0,4'h0, 1'b0,1'b1,1'b0,1'b0,2'd0},
    '{4'hB,4'h0,4'h3,4'h2,1'b0, 4'h4,4'h4,4'h4,4'h3, 3'd4,1'b0,4'h0, 1'b1,1'b0,1'b1,1'b0,2'd0},
    '{4'hB,4'h0,4'h4,4'h2,1'b0, 4'h4,4'h4,4'h4,4'h4, 3'd4,1'b0,4'h0, 1'b1,1'b0,1'b1,1'b0,2'd0},
    '{4'hC,4'h2,4'h1,4'h2,1'b1, 4'h8,4'h8,4'h8,4'h8, 3'd0,1'b0,4'h0, 1'b0,1'b0,1'b0,1'b0,2'd0},
    '{4'hF,4'h3,4'h1,4'h2,1'b1, 4'h8,4'h8,4'h8,4'h8, 3'd0,1'b0,4'h0, 1'b0,1'b0,1'b0,1'b0,2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  op_code, fn_code, ra_id, rb_id;
  logic [31:0] const_w, seq_pc, rd_a, rd_b, alu_res, mem_rdata;
  logic        br_take;
  logic [3:0]  src_a, src_b, dst_alu, dst_mem, alu_fn;
  logic [31:0] alu_in_a, alu_in_b, mem_addr, mem_wdata, next_pc;
  logic        mem_rd, mem_wr;

  cpu_step_ctrl uut (
    .op_code(op_code), .fn_code(fn_code), .ra_id(ra_id), .rb_id(rb_id),
    .const_w(const_w), .seq_pc(seq_pc), .rd_a(rd_a), .rd_b(rd_b),
    .alu_res(alu_res), .mem_rdata(mem_rdata), .br_take(br_take),
    .src_a(src_a), .src_b(src_b), .dst_alu(dst_alu), .dst_mem(dst_mem),
    .alu_in_a(alu_in_a), .alu_in_b(alu_in_b), .alu_fn(alu_fn),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .next_pc(next_pc)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    op_code = v.op; fn_code = v.fn; ra_id = v.ra; rb_id = v.rb; br_take = v.br;
    const_w = C; seq_pc = P; rd_a = A; rd_b = B; alu_res = E; mem_rdata = M;
    #5;
  endtask

  function automatic logic [31:0] exp_a(input logic [2:0] s);
    case (s)
      3'd1: return A;
      3'd2: return C;
      3'd3: return -32'sd4;
      3'd4: return 32'd4;
      default: return 32'd0;
    endcase
  endfunction

  initial begin
    op_code = '0; fn_code = '0; ra_id = '0; rb_id = '0; br_take = 1'b0;
    const_w = '0; seq_pc = '0; rd_a = '0; rd_b = '0; alu_res = '0; mem_rdata = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #5;
    chk("R8 idle strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
    chk("R3 idle dst_alu", 32'(dst_alu), 32'd8);

    for (int i = 0; i < NV; i++) begin
      vec_t v = TBL[i];
      drive(v);
      chk("R1 src_a", 32'(src_a), 32'(v.sa));
      chk("R2 src_b", 32'(src_b), 32'(v.sb));
      chk("R3 dst_alu", 32'(dst_alu), 32'(v.de));
      chk("R4 dst_mem", 32'(dst_mem), 32'(v.dm));
      chk("R5 alu_in_a", alu_in_a, exp_a(v.asel));
      chk("R6 alu_in_b", alu_in_b, v.bzero ? 32'd0 : B);
      chk("R7 alu_fn", 32'(alu_fn), 32'(v.fe));
      chk("R8 mem strobes", {30'd0, mem_rd, mem_wr}, {30'd0, v.rd, v.wr});
      chk("R9 mem_addr", mem_addr, v.addr_a ? A : E);
      chk("R10 mem_wdata", mem_wdata, v.wd_p ? P : A);
      chk("R11 next_pc", next_pc, v.pcs == 2'd1 ? C : v.pcs == 2'd2 ? M : P);
      if (v.op > 4'hB)
        chk("R12 unused opcode quiet", {27'd0, mem_rd, mem_wr, alu_fn[2:0]}, 32'd0);
    end

    drive('{4'hD,4'h1,4'h4,4'h4,1'b1, 4'h8,4'h8,4'h8,4'h8, 3'd0,1'b0,4'h0, 1'b0,1'b0,1'b0,1'b0,2'd0});
    chk("R12 unused opcode srcs", {24'd0, src_a, src_b}, 32'h88);
    chk("R12 unused opcode next_pc", next_pc, P);
    chk("R12 unused opcode fn", 32'(alu_fn), 32'd0);

    drive('{4'h9,4'h0,4'h4,4'h4,1'b0, 4'h4,4'h4,4'h4,4'h8, 3'd4,1'b0,4'h0, 1'b1,1'b0,1'b1,1'b0,2'd2});
    mem_rdata = 32'hCAFE_0010; #2;
    chk("R11 ret follows mem data", next_pc, 32'hCAFE_0010);
    rd_a = 32'h0000_0F00; #2;
    chk("R9 ret addr follows old sp", mem_addr, 32'h0000_0F00);

    drive('{4'h7,4'h0,4'h1,4'h2,1'b1, 4'h8,4'h8,4'h8,4'h8, 3'd0,1'b0,4'h0, 1'b0,1'b0,1'b0,1'b0,2'd1});
    br_take = 1'b0; #2;
    chk("R11 jump not taken", next_pc, P);
    br_take = 1'b1; const_w = 32'h0000_0004; #2;
    chk("R11 jump taken new target", next_pc, 32'h0000_0004);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule